// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Transmitter

This block turns parallel left and right audio samples into a three-wire serial audio stream: a bit clock, a frame clock that separates or marks the channels, and one serial data line. One stereo frame is 64 bit periods long, which gives two channel slots of 32 bit periods each. Four framing formats are supported. In I2S the word starts one bit late. In left-justified the word starts on the slot edge. In right-justified the word ends on the slot edge. In DSP pulse mode a single frame pulse is sent and the two words follow back to back. The word width is 16, 20 or 24 bits. The bit clock and the frame clock each have a polarity control.

The block can run as clock master or as clock slave. As master, each `bit_tick` pulse toggles the bit clock it drives, so one bit period lasts two ticks. As slave, it synchronises the external bit clock and frame clock into the system clock domain and follows their falling edges. A configuration load pulse copies the configuration pins into the active configuration and restarts the frame.

Samples arrive on a valid/ready stream into a one-pair holding stage. `s_ready` is high while the stage is empty. It goes high again at each frame start, which requests the next pair one frame ahead of its use. A pair accepted during a frame is transmitted in the next frame. The source may hold `s_valid` low for as long as it likes, and the data must stay stable only while `s_valid` is high and `s_ready` is low. If no pair has been accepted by a frame start, that frame carries zeros.

Top module: `aud_ser_tx`

## Requirements
- R1: After reset the active configuration is I2S, 24-bit words, normal polarities and slave clocking. `clk_drive`, `bit_clk_out`, `frame_clk_out` and `ser_data` are all low, and `s_ready` is high.
- R2: While `cfg_load` is high at a clock edge, the active configuration takes the configuration pins at that edge. The bit clock phase, the serial data and the frame clock output return to low, and the next bit period starts a new frame. `cfg_fmt` encodes the format as 0 = I2S, 1 = left-justified, 2 = right-justified, 3 = DSP. `cfg_wlen` encodes the width as 0 = 16, 1 = 20, 2 or 3 = 24.
- R3: As master, `clk_drive` is high and every `bit_tick` toggles the bit clock. A frame holds 64 bit periods. In the non-DSP formats the frame clock (normal polarity) is low for positions 0–31, which form the left slot, and high for positions 32–63, which form the right slot.
- R4: `ser_data` and the master frame clock change only at a bit-clock falling edge (normal polarity). `ser_data` is stable at every other time.
- R5: In I2S the MSB sits in bit period 1 of each slot.
- R6: In left-justified the MSB sits in bit period 0 of each slot.
- R7: In right-justified the LSB sits in bit period 31 of each slot.
- R8: In DSP mode the master frame clock is high only during bit period 0 of the frame. The left word starts at period 0 and the right word starts at period W.
- R9: Only bits W-1..0 of each sample are sent, MSB first. Every bit period outside a word is driven low.
- R10: `cfg_bit_clk_inv` inverts the driven bit clock and the sensed bit clock. `cfg_frame_clk_inv` does the same for the frame clock.
- R11: As slave, `clk_drive`, `bit_clk_out` and `frame_clk_out` are low and `bit_tick` is ignored. A frame-clock change seen at a falling bit-clock edge restarts the slot: position 0 if the new level is low, position 32 if it is high. In DSP mode a rising frame clock restarts the frame at position 0.
- R12: `s_ready` is low while a pair is held. It returns high at each frame start, when the held pair moves into the frame being sent. A frame that starts with nothing held is sent as zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Copy configuration pins into the active configuration and restart the frame |
| cfg_fmt | input | 2 | Framing format code |
| cfg_wlen | input | 2 | Word width code |
| cfg_bit_clk_inv | input | 1 | Invert bit clock polarity |
| cfg_frame_clk_inv | input | 1 | Invert frame clock polarity |
| cfg_master | input | 1 | 1 = drive the clocks, 0 = follow external clocks |
| bit_tick | input | 1 | Master half-bit-period enable |
| bit_clk_in | input | 1 | External bit clock (slave) |
| frame_clk_in | input | 1 | External frame clock (slave) |
| bit_clk_out | output | 1 | Driven bit clock (master) |
| frame_clk_out | output | 1 | Driven frame clock (master) |
| clk_drive | output | 1 | High while the clock outputs are driven |
| ser_data | output | 1 | Serial audio data |
| s_valid | input | 1 | Stereo pair valid |
| s_ready | output | 1 | Holding stage empty |
| s_left | input | DW | Left sample, right-aligned |
| s_right | input | DW | Right sample, right-aligned |

## Verification
Assertions check on every cycle that the serial data moves only with a bit-period strobe. They also check that a master strobe leaves the bit clock at its idle-low phase, that the master position counter advances by one per bit period, that the DSP frame pulse is absent away from period 0, and that the holding stage empties and refills as the handshake requires. Bit placement can only be shown by the bench scenarios: MSB and LSB positions for each format and width, zero padding, polarity inversion, slave resynchronisation to external clock edges, and zero frames on underrun. In those scenarios a behavioural reference model is compared with every output on every clock.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_DSP = 2'd3
  } fmt_e;

  typedef struct packed {
    fmt_e       fmt;
    logic [1:0] wlen;
    logic       bit_inv;
    logic       frame_inv;
    logic       master;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{fmt: FMT_I2S, wlen: 2'd2, bit_inv: 1'b0,
                                 frame_inv: 1'b0, master: 1'b0};

endpackage

// File: rtl/aud_tx_timing.sv
module aud_tx_timing #(
  parameter int POS_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             master,
  input  logic             dsp,
  input  logic             bit_inv,
  input  logic             frame_inv,
  input  logic             bit_tick,
  input  logic             bit_clk_in,
  input  logic             frame_clk_in,
  output logic             bphase,
  output logic             strobe,
  output logic [POS_W-1:0] next_pos
);
  localparam logic [POS_W-1:0] LAST = '1;
  localparam logic [POS_W-1:0] HALF = POS_W'(1) << (POS_W - 1);

  logic [2:0]       bsync;
  logic [1:0]       fsync;
  logic             lr_last;
  logic [POS_W-1:0] pos;
  logic             ext_fall;
  logic             lr_now;

  assign ext_fall = bsync[2] & ~bsync[1];
  assign lr_now   = fsync[1];

  always_comb begin
    strobe   = master ? (bit_tick & bphase) : ext_fall;
    next_pos = pos + 1'b1;
    if (!master) begin
      if (dsp) begin
        if (lr_now && !lr_last) next_pos = '0;
      end else if (lr_now != lr_last) begin
        next_pos = lr_now ? HALF : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsync <= '0;
      fsync <= '0;
    end else begin
      bsync <= {bsync[1:0], bit_clk_in ^ bit_inv};
      fsync <= {fsync[0], frame_clk_in ^ frame_inv};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos     <= LAST;
      lr_last <= 1'b0;
      bphase  <= 1'b0;
    end else if (restart) begin
      pos     <= LAST;
      lr_last <= 1'b0;
      bphase  <= 1'b0;
    end else begin
      if (strobe) begin
        pos     <= next_pos;
        lr_last <= lr_now;
      end
      if (master && bit_tick) bphase <= ~bphase;
    end
  end

  // R3: a master bit period advances the frame position by exactly one
  assert_master_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (master && strobe && !restart) |=> (pos == $past(pos) + 1'b1));

endmodule

// File: rtl/aud_tx_sample.sv
module aud_tx_sample #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_ld,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_left,
  input  logic [DW-1:0] s_right,
  output logic [DW-1:0] word_l,
  output logic [DW-1:0] word_r
);
  logic          full;
  logic [DW-1:0] hold_l, hold_r, cur_l, cur_r;
  logic          take;

  assign s_ready = ~full;
  assign take    = s_valid & ~full;
  assign word_l  = frame_ld ? (full ? hold_l : '0) : cur_l;
  assign word_r  = frame_ld ? (full ? hold_r : '0) : cur_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      hold_l <= '0;
      hold_r <= '0;
      cur_l  <= '0;
      cur_r  <= '0;
    end else begin
      if (frame_ld) begin
        cur_l <= word_l;
        cur_r <= word_r;
        full  <= 1'b0;
      end
      if (take) begin
        hold_l <= s_left;
        hold_r <= s_right;
        full   <= 1'b1;
      end
    end
  end

  // R12: an accepted pair closes the request window
  assert_take_closes_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  // R12: a frame start reopens the window when nothing new arrives
  assert_frame_reopens_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ld && !s_valid) |=> s_ready);

endmodule

// File: rtl/aud_tx_bitsel.sv
module aud_tx_bitsel
  import aud_tx_pkg::*;
#(
  parameter int DW    = 24,
  parameter int POS_W = 6
) (
  input  fmt_e           fmt,
  input  logic [POS_W:0] wbits,
  input  logic [POS_W-1:0] pos,
  input  logic [DW-1:0]  wl,
  input  logic [DW-1:0]  wr,
  output logic           bit_out
);
  localparam int IW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [POS_W:0] SLOT_V = (POS_W + 1)'(1) << (POS_W - 1);

  logic [POS_W:0] p, k, idx;
  logic           use_r, hit;
  logic [DW-1:0]  word;

  always_comb begin
    p     = {1'b0, pos};
    k     = {2'b00, pos[POS_W-2:0]};
    use_r = pos[POS_W-1];
    hit   = 1'b0;
    idx   = '0;
    unique case (fmt)
      FMT_I2S: begin
        hit = (k >= (POS_W + 1)'(1)) && (k <= wbits);
        idx = wbits - k;
      end
      FMT_LJ: begin
        hit = k < wbits;
        idx = wbits - (POS_W + 1)'(1) - k;
      end
      FMT_RJ: begin
        hit = k >= (SLOT_V - wbits);
        idx = SLOT_V - (POS_W + 1)'(1) - k;
      end
      FMT_DSP: begin
        if (p < wbits) begin
          use_r = 1'b0;
          hit   = 1'b1;
          idx   = wbits - (POS_W + 1)'(1) - p;
        end else if (p < (wbits << 1)) begin
          use_r = 1'b1;
          hit   = 1'b1;
          idx   = (wbits << 1) - (POS_W + 1)'(1) - p;
        end
      end
      default: hit = 1'b0;
    endcase
    word    = use_r ? wr : wl;
    bit_out = hit & word[idx[IW-1:0]];
  end

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
  import aud_tx_pkg::*;
#(
  parameter int DW        = 24,
  parameter int SLOT_BITS = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [1:0]    cfg_fmt,
  input  logic [1:0]    cfg_wlen,
  input  logic          cfg_bit_clk_inv,
  input  logic          cfg_frame_clk_inv,
  input  logic          cfg_master,
  input  logic          bit_tick,
  input  logic          bit_clk_in,
  input  logic          frame_clk_in,
  output logic          bit_clk_out,
  output logic          frame_clk_out,
  output logic          clk_drive,
  output logic          ser_data,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_left,
  input  logic [DW-1:0] s_right
);
  localparam int POS_W = $clog2(2 * SLOT_BITS);
  localparam int CW    = POS_W + 1;

  cfg_t             act;
  logic [CW-1:0]    wbits;
  logic             bphase, strobe, frame_ld, nbit;
  logic [POS_W-1:0] next_pos;
  logic [DW-1:0]    word_l, word_r;
  logic             sdata_q, lr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        act <= CFG_RESET;
    else if (cfg_load) act <= '{fmt: fmt_e'(cfg_fmt), wlen: cfg_wlen,
                                bit_inv: cfg_bit_clk_inv,
                                frame_inv: cfg_frame_clk_inv,
                                master: cfg_master};
  end

  always_comb begin
    unique case (act.wlen)
      2'd0:    wbits = CW'(16);
      2'd1:    wbits = CW'(20);
      default: wbits = CW'(24);
    endcase
  end

  aud_tx_timing #(.POS_W(POS_W)) u_timing (
    .clk(clk), .rst_n(rst_n), .restart(cfg_load),
    .master(act.master), .dsp(act.fmt == FMT_DSP),
    .bit_inv(act.bit_inv), .frame_inv(act.frame_inv),
    .bit_tick(bit_tick), .bit_clk_in(bit_clk_in), .frame_clk_in(frame_clk_in),
    .bphase(bphase), .strobe(strobe), .next_pos(next_pos)
  );

  assign frame_ld = strobe & ~cfg_load & (next_pos == '0);

  aud_tx_sample #(.DW(DW)) u_sample (
    .clk(clk), .rst_n(rst_n), .frame_ld(frame_ld),
    .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right),
    .word_l(word_l), .word_r(word_r)
  );

  aud_tx_bitsel #(.DW(DW), .POS_W(POS_W)) u_bitsel (
    .fmt(act.fmt), .wbits(wbits), .pos(next_pos),
    .wl(word_l), .wr(word_r), .bit_out(nbit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdata_q <= 1'b0;
      lr_q    <= 1'b0;
    end else if (cfg_load) begin
      sdata_q <= 1'b0;
      lr_q    <= 1'b0;
    end else if (strobe) begin
      sdata_q <= nbit;
      lr_q    <= (act.fmt == FMT_DSP) ? (next_pos == '0) : next_pos[POS_W-1];
    end
  end

  assign ser_data      = sdata_q;
  assign clk_drive     = act.master;
  assign bit_clk_out   = act.master & (bphase ^ act.bit_inv);
  assign frame_clk_out = act.master & (lr_q ^ act.frame_inv);

  // R4: serial data holds between bit-period strobes
  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !cfg_load) |=> $stable(ser_data));

  // R4: a master strobe leaves the bit clock at its falling-edge level
  assert_shift_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act.master && strobe && !cfg_load) |=> (clk_drive && bit_clk_out == act.bit_inv));

  // R8: DSP frame pulse is absent away from frame period 0
  assert_dsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (act.master && act.fmt == FMT_DSP && strobe && !cfg_load && next_pos != '0)
      |=> (frame_clk_out == act.frame_inv));

endmodule

// File: tb/tb_aud_ser_tx.sv
`timescale 1ns/1ps
module tb_aud_ser_tx;
  localparam int DW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0;
  logic [1:0] cfg_fmt = 2'd0, cfg_wlen = 2'd2;
  logic cfg_bit_clk_inv = 1'b0, cfg_frame_clk_inv = 1'b0, cfg_master = 1'b0;
  logic bit_tick = 1'b0, bit_clk_in = 1'b0, frame_clk_in = 1'b0;
  logic bit_clk_out, frame_clk_out, clk_drive, ser_data, s_ready;
  logic s_valid = 1'b0;
  logic [DW-1:0] s_left = '0, s_right = '0;

  always #10 clk = ~clk;

  aud_ser_tx #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_fmt(cfg_fmt),
    .cfg_wlen(cfg_wlen), .cfg_bit_clk_inv(cfg_bit_clk_inv),
    .cfg_frame_clk_inv(cfg_frame_clk_inv), .cfg_master(cfg_master),
    .bit_tick(bit_tick), .bit_clk_in(bit_clk_in), .frame_clk_in(frame_clk_in),
    .bit_clk_out(bit_clk_out), .frame_clk_out(frame_clk_out),
    .clk_drive(clk_drive), .ser_data(ser_data), .s_valid(s_valid),
    .s_ready(s_ready), .s_left(s_left), .s_right(s_right)
  );

  int n_checks = 0, n_errors = 0;
  string tag = "R1";
  bit chk_on = 0, done = 0;
  bit tick_run = 0, slave_run = 0, feed_en = 0;

  // reference model state
  int m_fmt, m_wlen, m_pos;
  bit m_binv, m_finv, m_mst, m_bph, m_lrlast, m_lrq, m_sd, m_full, took;
  logic [DW-1:0] m_hl, m_hr, m_cl, m_cr;
  bit sb1, sb2, sb3, sl1, sl2;

  function automatic int wsel(int c);
    return (c == 0) ? 16 : (c == 1) ? 20 : 24;
  endfunction

  function automatic bit ref_bit(int fmt, int w, int p, logic [DW-1:0] wl, logic [DW-1:0] wr);
    int k = p % 32;
    logic [DW-1:0] word = (p >= 32) ? wr : wl;
    case (fmt)
      0: if (k >= 1 && k <= w) return word[w - k];
      1: if (k < w) return word[w - 1 - k];
      2: if (k >= 32 - w) return word[31 - k];
      default: begin
        if (p < w) return wl[w - 1 - p];
        if (p < 2 * w) return wr[2 * w - 1 - p];
      end
    endcase
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_fmt = 0; m_wlen = 2; m_binv = 0; m_finv = 0; m_mst = 0;
      m_pos = 63; m_bph = 0; m_lrlast = 0; m_lrq = 0; m_sd = 0; m_full = 0;
      m_hl = '0; m_hr = '0; m_cl = '0; m_cr = '0; took = 0;
      sb1 = 0; sb2 = 0; sb3 = 0; sl1 = 0; sl2 = 0;
    end else begin
      bit strobe, lrnow, acc, fld, nb;
      int np;
      logic [DW-1:0] wl, wr;
      lrnow = sl2;
      strobe = m_mst ? (bit_tick && m_bph) : (sb3 && !sb2);
      np = (m_pos + 1) % 64;
      if (!m_mst) begin
        if (m_fmt == 3) begin
          if (lrnow && !m_lrlast) np = 0;
        end else if (lrnow != m_lrlast) np = lrnow ? 32 : 0;
      end
      acc = s_valid && !m_full;
      fld = strobe && !cfg_load && np == 0;
      wl = fld ? (m_full ? m_hl : '0) : m_cl;
      wr = fld ? (m_full ? m_hr : '0) : m_cr;
      nb = ref_bit(m_fmt, wsel(m_wlen), np, wl, wr);
      sb3 = sb2; sb2 = sb1; sb1 = bit_clk_in ^ m_binv;
      sl2 = sl1; sl1 = frame_clk_in ^ m_finv;
      if (cfg_load) begin
        m_pos = 63; m_lrlast = 0; m_bph = 0; m_sd = 0; m_lrq = 0;
        m_fmt = int'(cfg_fmt); m_wlen = int'(cfg_wlen);
        m_binv = cfg_bit_clk_inv; m_finv = cfg_frame_clk_inv; m_mst = cfg_master;
      end else begin
        if (strobe) begin
          m_pos = np; m_lrlast = lrnow; m_sd = nb;
          m_lrq = (m_fmt == 3) ? (np == 0) : (np >= 32);
        end
        if (m_mst && bit_tick) m_bph = !m_bph;
      end
      if (fld) begin m_cl = wl; m_cr = wr; m_full = 0; end
      if (acc) begin m_hl = s_left; m_hr = s_right; m_full = 1; end
      took = acc;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (chk_on && !done) begin
      logic [4:0] act, exp;
      act = {clk_drive, bit_clk_out, frame_clk_out, ser_data, s_ready};
      exp = {m_mst, m_mst & (m_bph ^ m_binv), m_mst & (m_lrq ^ m_finv), m_sd, !m_full};
      n_checks++;
      if (act !== exp) begin
        n_errors++;
        $display("FAIL %s t=%0t {drive,bclk,fclk,data,ready} actual=%b expected=%b",
                 tag, $time, act, exp);
      end
    end
  end

  // master tick driver
  always @(negedge clk) bit_tick <= tick_run ? ~bit_tick : 1'b0;

  // external clock source for slave scenarios
  int ext_fmt = 0, ext_cnt = 0, ext_pos = 63;
  bit ext_ph = 0, ext_lr = 0, ext_binv = 0, ext_finv = 0;
  always @(negedge clk) begin
    if (slave_run) begin
      ext_cnt++;
      if (ext_cnt == 4) begin
        ext_cnt = 0;
        ext_ph = !ext_ph;
        if (!ext_ph) begin
          ext_pos = (ext_pos + 1) % 64;
          ext_lr = (ext_fmt == 3) ? (ext_pos == 0) : (ext_pos >= 32);
        end
      end
    end
    bit_clk_in <= ext_ph ^ ext_binv;
    frame_clk_in <= ext_lr ^ ext_finv;
  end

  // sample source
  always @(negedge clk) begin
    s_valid <= feed_en;
    if (took || !feed_en) begin
      s_left  <= DW'($urandom);
      s_right <= DW'($urandom);
    end
  end

  task automatic load(input int fmt, input int wl, input bit binv, input bit finv, input bit mst);
    @(negedge clk);
    cfg_fmt = 2'(fmt); cfg_wlen = 2'(wl);
    cfg_bit_clk_inv = binv; cfg_frame_clk_inv = finv; cfg_master = mst;
    cfg_load = 1'b1;
    tick_run = mst; slave_run = !mst;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic single(input string t, input bit ok, input int a, input int e);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", t, a, e);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state seen at the ports
    single("R1 clk_drive", clk_drive == 1'b0, clk_drive, 0);
    single("R1 s_ready", s_ready == 1'b1, s_ready, 1);
    single("R1 ser_data", ser_data == 1'b0, ser_data, 0);
    single("R1 bit_clk_out", bit_clk_out == 1'b0, bit_clk_out, 0);
    chk_on = 1;
    // R1/R11/R5: default slave I2S 24-bit following external clocks
    tag = "R1/R11/R5"; feed_en = 1; ext_fmt = 0; slave_run = 1;
    repeat (1600) @(negedge clk);
    tag = "R2/R3/R4/R5"; ext_fmt = 0;
    load(0, 2, 0, 0, 1); repeat (800) @(negedge clk);
    tag = "R6/R9"; load(1, 1, 0, 0, 1); repeat (800) @(negedge clk);
    tag = "R7/R9"; load(2, 0, 0, 0, 1); repeat (800) @(negedge clk);
    tag = "R8"; load(3, 2, 0, 0, 1); repeat (800) @(negedge clk);
    tag = "R8/R9"; load(3, 0, 0, 0, 1); repeat (800) @(negedge clk);
    tag = "R10"; load(0, 2, 1, 1, 1); repeat (800) @(negedge clk);
    tag = "R10/R11"; ext_fmt = 1; ext_binv = 1; ext_finv = 1;
    load(1, 2, 1, 1, 0); repeat (1600) @(negedge clk);
    tag = "R11/R7"; ext_binv = 0; ext_finv = 0;
    load(2, 1, 0, 0, 0); repeat (1600) @(negedge clk);
    tag = "R11/R8"; ext_fmt = 3;
    load(3, 1, 0, 0, 0); repeat (1600) @(negedge clk);
    tag = "R12"; feed_en = 0;
    load(1, 2, 0, 0, 1); repeat (800) @(negedge clk);
    feed_en = 1; repeat (800) @(negedge clk);
    // R11: bit_tick has no effect in slave mode
    tag = "R11"; load(0, 2, 0, 0, 0); tick_run = 1; repeat (400) @(negedge clk);
    single("R11 clk_drive in slave", clk_drive == 1'b0, clk_drive, 0);
    tick_run = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule